// File: doc/BRIEF.md
# Vertical Transfer Pulse Repeater with Line-Crossing Sweep

This block drives the four vertical transfer phases of an interline CCD. Each horizontal line, on the horizontal sync (HD) pulse, it can start a burst of repetitions of one programmable pulse pattern. A repetition is a fixed number of pixel clocks long, and each phase has its own on and off position inside that period. In normal timing the burst stays inside the line. A repetition that would still be running when the next HD arrives is never started.

Sweep timing is used to clear charge from the vertical registers before readout. It replaces the per-line burst with one long continuous run that ignores HD and spans as many lines as its repeat count needs. Sweep can only be enabled for the first and the last of the four line regions. The region holding the current line is found by comparing the external line counter with three start-line settings. All settings are copied into shadow registers on the vertical sync (VD) pulse and take effect from that frame on.

Top module: `vsg_sweep_top`

## Requirements
- R1: The mode, repeat counts, period, line length, region starts and toggle positions are sampled only on a clock edge where `vd_i` is high. Changes at other times have no effect until the next VD. All shadows reset to zero.
- R2: At an HD edge the line is in region 3 if `line_i` >= start[2], else region 2 if >= start[1], else region 1 if >= start[0], else region 0.
- R3: In normal timing, an HD edge starts `norm_rep_i` back-to-back repetitions of `rep_len_i` clocks, beginning the cycle after HD. Repetition k (from 0) is output only if (k+1)*`rep_len_i` <= `line_len_i`. A burst never starts when the period is zero or longer than the line.
- R4: While a repetition runs with phase position p (0 at its first clock), phase i differs from its idle level (default low) exactly when on[i] <= p < off[i]. With no repetition running, every phase is at its idle level.
- R5: The 2-bit mode selects where sweep is allowed. 0 allows it nowhere, 1 allows it in region 0, 2 allows it in region 3, and 3 allows it in both.
- R6: A sweep runs `sweep_rep0_i` (region 0) or `sweep_rep3_i` (region 3) repetitions continuously, up to 2048, and ignores every HD until it finishes.
- R7: A sweep starts on the first HD of an enabled region in a frame, and at most once per region per frame. After it ends, the phases are idle until the next HD, and that line gets normal timing.
- R8: `busy_o` is high exactly during the clocks of the sweep repetitions.
- R9: A sweep repeat count of zero disables sweep for that region. The line then gets normal timing.
- R10: A normal repeat count of zero leaves the phases idle on lines without sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hd_i | input | 1 | Horizontal sync, one clock high per line |
| vd_i | input | 1 | Vertical sync, loads the shadow settings |
| line_i | input | LINE_W | Current line number |
| region_start_i | input | 3*LINE_W | Start lines of regions 1, 2 and 3 |
| mode_i | input | 2 | Sweep enable mode (R5) |
| norm_rep_i | input | REP_W | Normal repetitions per line |
| sweep_rep0_i | input | REP_W | Sweep repetitions in region 0 |
| sweep_rep3_i | input | REP_W | Sweep repetitions in region 3 |
| rep_len_i | input | PER_W | Repetition period in clocks |
| line_len_i | input | LPOS_W | Clocks per line, used for the overlap test |
| tog_on_i | input | NPH*PER_W | Per-phase on position |
| tog_off_i | input | NPH*PER_W | Per-phase off position |
| v_o | output | NPH | Vertical phase outputs |
| busy_o | output | 1 | Sweep in progress |

## Verification
The bench runs a behavioural model and compares it with the outputs on every clock, across a sequence of frames. A burst that fits separates the basic repeat and pattern logic from the overlap suppression, and a burst that asks for more repetitions than fit exercises that suppression. Sweeps are run in each mode, including one that ends exactly on an HD edge, one that ends mid-line, a disabled zero count and a 2048-repetition run. Together these separate region gating, HD crossing, once-per-frame behaviour and the return to normal timing. Settings changed in the middle of a frame, and a zero normal count, show that only VD loads the settings and that idle lines stay quiet.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_NORM  = 2'd1,
      SQ_SWEEP = 2'd2
   } seq_e;

   localparam int NUM_REGION = 4;
   localparam int REG_W      = 2;
endpackage

// File: rtl/vsg_region_dec.sv
module vsg_region_dec #(
   parameter int LINE_W = 11
) (
   input  logic [LINE_W-1:0]                           line,
   input  logic [vsg_pkg::NUM_REGION-2:0][LINE_W-1:0]  starts,
   output logic [vsg_pkg::REG_W-1:0]                   region
);
   localparam int NB = vsg_pkg::NUM_REGION - 1;

   always_comb begin
      region = '0;
      for (int k = 0; k < NB; k++) begin
         if (line >= starts[k]) region = vsg_pkg::REG_W'(k + 1);
      end
   end
endmodule

// File: rtl/vsg_phase_dec.sv
module vsg_phase_dec #(
   parameter int              NPH        = 4,
   parameter int              PER_W      = 6,
   parameter logic [NPH-1:0]  IDLE_LEVEL = '0
) (
   input  logic                           active,
   input  logic [PER_W-1:0]               ph,
   input  logic [NPH-1:0][PER_W-1:0]      t_on,
   input  logic [NPH-1:0][PER_W-1:0]      t_off,
   output logic [NPH-1:0]                 v
);
   for (genvar i = 0; i < NPH; i++) begin : g_ph
      logic in_win;
      assign in_win = active && (ph >= t_on[i]) && (ph < t_off[i]);
      if (IDLE_LEVEL[i]) begin : g_hi
         assign v[i] = ~in_win;
      end else begin : g_lo
         assign v[i] = in_win;
      end
   end
endmodule

// File: rtl/vsg_seq.sv
module vsg_seq
   import vsg_pkg::*;
#(
   parameter int PER_W  = 6,
   parameter int REP_W  = 12,
   parameter int LPOS_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hd,
   input  logic              sweep_go,
   input  logic [REP_W-1:0]  sweep_tgt,
   input  logic              norm_ok,
   input  logic [REP_W-1:0]  norm_tgt,
   input  logic [PER_W-1:0]  per_len,
   input  logic [LPOS_W-1:0] line_len,
   output seq_e              st,
   output logic [PER_W-1:0]  ph
);
   localparam logic [LPOS_W-1:0] LMAX = '1;

   logic [REP_W-1:0]  rep, tgt;
   logic [LPOS_W-1:0] lpos, cur_len;
   logic [PER_W-1:0]  cur_per;
   logic              last_ph, fits;

   assign last_ph = (ph == cur_per - PER_W'(1));
   assign fits    = ({1'b0, lpos} + (LPOS_W+1)'(1) + (LPOS_W+1)'(cur_per))
                    <= {1'b0, cur_len};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SQ_IDLE;
         ph      <= '0;
         rep     <= '0;
         tgt     <= '0;
         lpos    <= '0;
         cur_len <= '0;
         cur_per <= '0;
      end else begin
         if (hd)                lpos <= '0;
         else if (lpos != LMAX) lpos <= lpos + LPOS_W'(1);
         if (hd) cur_len <= line_len;

         if (st == SQ_SWEEP) begin
            if (last_ph) begin
               ph  <= '0;
               rep <= rep + REP_W'(1);
               if (rep + REP_W'(1) == tgt) st <= SQ_IDLE;
            end else begin
               ph <= ph + PER_W'(1);
            end
         end else if (hd) begin
            ph      <= '0;
            rep     <= '0;
            cur_per <= per_len;
            if (sweep_go) begin
               st  <= SQ_SWEEP;
               tgt <= sweep_tgt;
            end else if (norm_ok) begin
               st  <= SQ_NORM;
               tgt <= norm_tgt;
            end else begin
               st  <= SQ_IDLE;
            end
         end else if (st == SQ_NORM) begin
            if (last_ph) begin
               ph  <= '0;
               rep <= rep + REP_W'(1);
               if ((rep + REP_W'(1) == tgt) || !fits) st <= SQ_IDLE;
            end else begin
               ph <= ph + PER_W'(1);
            end
         end
      end
   end

   // R3: a normal burst never runs past the end of its line
   p_norm_in_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_NORM) |-> (lpos < cur_len));

   // R6: HD does not interrupt a running sweep
   p_sweep_spans_hd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_SWEEP && hd && !last_ph) |=> (st == SQ_SWEEP));

   // R6: repetition count stays below its target while running
   p_rep_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st != SQ_IDLE) |-> (rep < tgt));

   // R4: phase position stays inside the period
   p_ph_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st != SQ_IDLE) |-> (ph < cur_per));
endmodule

// File: rtl/vsg_sweep_top.sv
module vsg_sweep_top
   import vsg_pkg::*;
#(
   parameter int              NPH        = 4,
   parameter int              PER_W      = 6,
   parameter int              LINE_W     = 11,
   parameter int              LPOS_W     = 12,
   parameter int              MAX_SWEEP  = 2048,
   parameter logic [NPH-1:0]  IDLE_LEVEL = '0,
   localparam int             REP_W      = $clog2(MAX_SWEEP + 1)
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   hd_i,
   input  logic                                   vd_i,
   input  logic [LINE_W-1:0]                      line_i,
   input  logic [NUM_REGION-2:0][LINE_W-1:0]      region_start_i,
   input  logic [1:0]                             mode_i,
   input  logic [REP_W-1:0]                       norm_rep_i,
   input  logic [REP_W-1:0]                       sweep_rep0_i,
   input  logic [REP_W-1:0]                       sweep_rep3_i,
   input  logic [PER_W-1:0]                       rep_len_i,
   input  logic [LPOS_W-1:0]                      line_len_i,
   input  logic [NPH-1:0][PER_W-1:0]              tog_on_i,
   input  logic [NPH-1:0][PER_W-1:0]              tog_off_i,
   output logic [NPH-1:0]                         v_o,
   output logic                                   busy_o
);
   localparam logic [REG_W-1:0] LAST_REG = REG_W'(NUM_REGION - 1);

   if (NPH < 1)          begin : g_bad_nph  $error("NPH must be at least 1"); end
   if (PER_W < 2)        begin : g_bad_per  $error("PER_W must be at least 2"); end
   if (LPOS_W < PER_W)   begin : g_bad_lpos $error("LPOS_W must cover PER_W"); end
   if (MAX_SWEEP < 1)    begin : g_bad_max  $error("MAX_SWEEP must be positive"); end

   logic [1:0]                          sh_mode;
   logic [REP_W-1:0]                    sh_norm, sh_sw0, sh_sw3;
   logic [PER_W-1:0]                    sh_per;
   logic [LPOS_W-1:0]                   sh_line;
   logic [NUM_REGION-2:0][LINE_W-1:0]   sh_start;
   logic [NPH-1:0][PER_W-1:0]           sh_on, sh_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_mode  <= '0;
         sh_norm  <= '0;
         sh_sw0   <= '0;
         sh_sw3   <= '0;
         sh_per   <= '0;
         sh_line  <= '0;
         sh_start <= '0;
         sh_on    <= '0;
         sh_off   <= '0;
      end else if (vd_i) begin
         sh_mode  <= mode_i;
         sh_norm  <= norm_rep_i;
         sh_sw0   <= sweep_rep0_i;
         sh_sw3   <= sweep_rep3_i;
         sh_per   <= rep_len_i;
         sh_line  <= line_len_i;
         sh_start <= region_start_i;
         sh_on    <= tog_on_i;
         sh_off   <= tog_off_i;
      end
   end

   logic [REG_W-1:0] region;

   vsg_region_dec #(.LINE_W(LINE_W)) u_region (
      .line   (line_i),
      .starts (sh_start),
      .region (region)
   );

   logic in_first, in_last, sweep_allowed, sweep_go, norm_ok;
   logic done_first, done_last;
   logic [REP_W-1:0] sweep_tgt;
   seq_e st;
   logic [PER_W-1:0] ph;

   assign in_first      = (region == '0);
   assign in_last       = (region == LAST_REG);
   assign sweep_allowed = (in_first && sh_mode[0]) || (in_last && sh_mode[1]);
   assign sweep_tgt     = in_first ? sh_sw0 : sh_sw3;
   assign sweep_go      = (sh_per != '0) &&
                          ((in_first && sh_mode[0] && !done_first && sh_sw0 != '0) ||
                           (in_last  && sh_mode[1] && !done_last  && sh_sw3 != '0));
   assign norm_ok       = (sh_norm != '0) && (sh_per != '0) &&
                          (LPOS_W'(sh_per) <= sh_line);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_first <= 1'b0;
         done_last  <= 1'b0;
      end else if (vd_i) begin
         done_first <= 1'b0;
         done_last  <= 1'b0;
      end else if (hd_i && st != SQ_SWEEP && sweep_go) begin
         if (in_first) done_first <= 1'b1;
         else          done_last  <= 1'b1;
      end
   end

   vsg_seq #(.PER_W(PER_W), .REP_W(REP_W), .LPOS_W(LPOS_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .hd        (hd_i),
      .sweep_go  (sweep_go),
      .sweep_tgt (sweep_tgt),
      .norm_ok   (norm_ok),
      .norm_tgt  (sh_norm),
      .per_len   (sh_per),
      .line_len  (sh_line),
      .st        (st),
      .ph        (ph)
   );

   vsg_phase_dec #(.NPH(NPH), .PER_W(PER_W), .IDLE_LEVEL(IDLE_LEVEL)) u_phase (
      .active (st != SQ_IDLE),
      .ph     (ph),
      .t_on   (sh_on),
      .t_off  (sh_off),
      .v      (v_o)
   );

   assign busy_o = (st == SQ_SWEEP);

   // R5: a sweep only begins in a region the mode enables
   p_sweep_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(sweep_allowed));

   // R1: shadow settings hold between VD pulses
   p_shadow_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !vd_i |=> ($stable(sh_mode) && $stable(sh_sw0) && $stable(sh_sw3) && $stable(sh_per)));

   // R7: a finished sweep leaves the phases idle until the next HD
   p_idle_after_sweep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && !$past(hd_i)) |-> (v_o == IDLE_LEVEL));
endmodule

// File: tb/sim_vsg_sweep_top.sv
module sim_vsg_sweep_top;
   localparam int CLK_P  = 10;
   localparam int NPH    = 4;
   localparam int PER_W  = 6;
   localparam int LINE_W = 11;
   localparam int LPOS_W = 12;
   localparam int REP_W  = 12;
   localparam int LMAX   = (1 << LPOS_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hd = 1'b0, vd = 1'b0;
   logic [LINE_W-1:0] line = '0;
   logic [2:0][LINE_W-1:0] starts = '0;
   logic [1:0] mode = '0;
   logic [REP_W-1:0] norm_rep = '0, sw0 = '0, sw3 = '0;
   logic [PER_W-1:0] per = '0;
   logic [LPOS_W-1:0] llen = '0;
   logic [NPH-1:0][PER_W-1:0] ton = '0, toff = '0;
   logic [NPH-1:0] v;
   logic busy;

   always #(CLK_P/2) clk = ~clk;

   vsg_sweep_top u0 (
      .clk(clk), .rst_n(rst_n), .hd_i(hd), .vd_i(vd), .line_i(line),
      .region_start_i(starts), .mode_i(mode), .norm_rep_i(norm_rep),
      .sweep_rep0_i(sw0), .sweep_rep3_i(sw3), .rep_len_i(per),
      .line_len_i(llen), .tog_on_i(ton), .tog_off_i(toff),
      .v_o(v), .busy_o(busy)
   );

   int checks = 0, fails = 0;
   string tag = "R4";
   bit cmp_en = 1'b0;
   int busy_cycles = 0;

   // behavioural reference: shadows, per-region once flags, burst state
   int s_mode, s_norm, s_sw0, s_sw3, s_per, s_line;
   int s_start[3];
   int s_on[NPH], s_off[NPH];
   bit d0, d3;
   int ms, mph, mrep, mtgt, mlpos, mlen, mper;

   always @(posedge clk) begin
      if (!rst_n) begin
         s_mode = 0; s_norm = 0; s_sw0 = 0; s_sw3 = 0; s_per = 0; s_line = 0;
         for (int k = 0; k < 3; k++) s_start[k] = 0;
         for (int k = 0; k < NPH; k++) begin s_on[k] = 0; s_off[k] = 0; end
         d0 = 0; d3 = 0; ms = 0; mph = 0; mrep = 0; mtgt = 0; mlpos = 0; mlen = 0; mper = 0;
      end else begin
         int rg;
         bit go, ok;
         rg = 0;
         if (int'(line) >= s_start[2]) rg = 3;
         else if (int'(line) >= s_start[1]) rg = 2;
         else if (int'(line) >= s_start[0]) rg = 1;
         go = (s_per != 0) && ((rg == 0 && s_mode[0] && !d0 && s_sw0 != 0) ||
                               (rg == 3 && s_mode[1] && !d3 && s_sw3 != 0));
         ok = (s_norm != 0) && (s_per != 0) && (s_per <= s_line);
         if (ms == 2) begin
            if (mph == mper - 1) begin
               mph = 0; mrep++;
               if (mrep == mtgt) ms = 0;
            end else mph++;
         end else if (hd) begin
            mph = 0; mrep = 0; mper = s_per; mlen = s_line;
            if (go) begin
               ms = 2; mtgt = (rg == 0) ? s_sw0 : s_sw3;
               if (rg == 0) d0 = 1; else d3 = 1;
            end else if (ok) begin
               ms = 1; mtgt = s_norm;
            end else ms = 0;
         end else if (ms == 1) begin
            if (mph == mper - 1) begin
               mph = 0; mrep++;
               if (mrep == mtgt || (mlpos + 1 + mper) > mlen) ms = 0;
            end else mph++;
         end
         if (hd) mlpos = 0; else if (mlpos < LMAX) mlpos++;
         if (vd) begin
            s_mode = mode; s_norm = norm_rep; s_sw0 = sw0; s_sw3 = sw3;
            s_per = per; s_line = llen;
            for (int k = 0; k < 3; k++) s_start[k] = starts[k];
            for (int k = 0; k < NPH; k++) begin s_on[k] = ton[k]; s_off[k] = toff[k]; end
            d0 = 0; d3 = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         logic [NPH-1:0] ev;
         logic eb;
         for (int k = 0; k < NPH; k++)
            ev[k] = (ms != 0) && (mph >= s_on[k]) && (mph < s_off[k]);
         eb = (ms == 2);
         checks++;
         if (v !== ev) begin
            fails++;
            $display("FAIL %s phases: actual %b expected %b at %0t", tag, v, ev, $time);
         end
         checks++;
         if (busy !== eb) begin
            fails++;
            $display("FAIL R8 (%s) busy: actual %b expected %b at %0t", tag, busy, eb, $time);
         end
         if (busy) busy_cycles++;
      end
   end

   task automatic cyc(input logic h, input int ln);
      @(posedge clk); #1;
      hd = h; vd = 1'b0; line = LINE_W'(ln);
   endtask

   task automatic run_line(input int ln, input int len);
      cyc(1'b1, ln);
      for (int c = 1; c < len; c++) cyc(1'b0, ln);
   endtask

   task automatic frame(input int first, input int last, input int len);
      @(posedge clk); #1; vd = 1'b1; hd = 1'b0;
      @(posedge clk); #1; vd = 1'b0;
      for (int l = first; l <= last; l++) run_line(l, len);
   endtask

   initial begin
      #(CLK_P * 150000);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      starts[0] = 3; starts[1] = 5; starts[2] = 7;
      ton[0] = 0; toff[0] = 4;
      ton[1] = 2; toff[1] = 6;
      ton[2] = 4; toff[2] = 8;
      ton[3] = 1; toff[3] = 3;
      repeat (3) @(negedge clk);
      // reset state: idle phases, not busy (R4, R8)
      checks++;
      if (v !== '0) begin fails++; $display("FAIL R4 reset phases: actual %b expected 0000", v); end
      checks++;
      if (busy !== 1'b0) begin fails++; $display("FAIL R8 reset busy: actual %b expected 0", busy); end
      @(posedge clk); #1; rst_n = 1'b1;
      cmp_en = 1'b1;

      // R3 R4: bursts that fit inside the line
      tag = "R3"; mode = 0; per = 8; norm_rep = 4; llen = 40;
      frame(0, 3, 40);
      // R3: more repetitions requested than fit before next HD
      norm_rep = 8;
      frame(0, 3, 40);
      // R2 R5 R6: sweep in region 0 ending exactly on an HD edge
      tag = "R6"; mode = 1; sw0 = 10; sw3 = 5; norm_rep = 2;
      frame(0, 9, 40);
      // R5 R7: sweep only in region 3, ends mid-line then normal next line
      tag = "R7"; mode = 2; per = 6; sw3 = 5;
      frame(0, 9, 40);
      // R2 R5 R9: both regions enabled, region 0 count zero
      tag = "R9"; mode = 3; sw0 = 0; sw3 = 7;
      frame(0, 9, 40);
      // R1: settings changed mid-frame must not act before VD
      tag = "R1"; mode = 0; norm_rep = 3;
      @(posedge clk); #1; vd = 1'b1;
      @(posedge clk); #1; vd = 1'b0;
      mode = 1; sw0 = 20; norm_rep = 1; per = 4;
      for (int l = 0; l <= 4; l++) run_line(l, 40);
      // R10: zero normal count keeps phases idle
      tag = "R10"; mode = 0; norm_rep = 0; per = 8;
      frame(0, 3, 40);
      // R6 R7: maximum-length sweep across many lines, then normal lines
      tag = "R6"; mode = 1; sw0 = 2048; per = 2; norm_rep = 3;
      ton[0] = 0; toff[0] = 1; ton[1] = 1; toff[1] = 2;
      busy_cycles = 0;
      frame(0, 0, 40);
      for (int l = 1; l <= 108; l++) run_line(0, 40);
      checks++;
      if (busy_cycles != 4096) begin
         fails++;
         $display("FAIL R6 sweep length: actual %0d expected 4096", busy_cycles);
      end
      repeat (4) @(posedge clk);
      cmp_en = 1'b0;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule